// File: doc/BRIEF.md
# Variable-Ratio Pixel Clock Enable Generator

The block sits on the master clock of a video timing path. It produces two single-cycle enables: a serial-clock enable and a pixel-clock enable that fires on every second serial tick. The pixel enable steps an external horizontal counter. That counter's value comes back into the block, together with a mode select, and the block uses both to choose whether each serial tick lasts 4 or 5 master clocks.

In the narrow mode every serial tick is 5 master clocks long, so a pixel takes 10. In the wide mode the normal tick is 4 master clocks. Inside the horizontal sync window the block mixes 4- and 5-clock ticks in a fixed order, and one back-porch position uses 5-clock ticks. This makes a wide-mode line exactly as long as a narrow-mode line: 3420 master clocks. The ratio is chosen for every serial tick from the live horizontal count and from which half of the pixel is in progress.

The enables are plain control pins. There is no data stream at the edge of the block, so there is no valid/ready handshake.

Top module: `pixclk_enable_gen`

## Requirements
- R1: While `rst_n` is low, and in the first master cycle after its release, `sclk_en` and `pix_en` are both low.
- R2: With `wide_mode` = 0, `sclk_en` fires once every 5 master clocks, whatever value `hcount` holds.
- R3: `pix_en` is high only together with `sclk_en`, on every second serial tick. After reset the first serial tick is the first half of a pixel, so the 2nd, 4th, 6th and later ticks carry `pix_en`.
- R4: With `wide_mode` = 1 and `hcount` outside 0x1CD..0x1ED, every serial tick lasts 4 master clocks.
- R5: With `wide_mode` = 1 and `hcount` in 0x1CD..0x1EC, each tick has an index i = 2*(hcount-0x1CD)+h, where h is 0 for the first tick of a pixel and 1 for the second. Ticks with i in {15,16,32,33,49,50} last 4 clocks and all other ticks last 5. The 64 ticks of the window therefore sum to 314 clocks.
- R6: With `wide_mode` = 1 and `hcount` = 0x1ED, both serial ticks of that pixel last 5 master clocks.
- R7: When the counter steps on `pix_en` through 0x000..0x127 and then 0x1D2..0x1FF (narrow mode), or through 0x000..0x16C and then 0x1C9..0x1FF (wide mode), one full line takes 3420 master clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 selects the wide mode with a mixed ratio, 0 selects the narrow mode with a fixed ratio |
| hcount | input | 9 | Current horizontal count from the external counter |
| sclk_en | output | 1 | Serial-clock enable, one master cycle wide |
| pix_en | output | 1 | Pixel-clock enable, one master cycle wide, coincides with every second `sclk_en` |

## Verification
Two things can happen in the same master cycle: a pixel step, which changes `hcount`, and a switch of the divide ratio. They coincide where a pixel step carries the count into or out of the sync window (0x1CC to 0x1CD, 0x1EC to 0x1ED, 0x1ED to 0x1EE). The ratio can also switch in the middle of a pixel, at a half-pixel boundary (i = 14 to 15, 16 to 17, and so on), where `hcount` does not change at all. The bench reproduces both cases by stepping a model counter one cycle after each `pix_en`, the way a real register would. It then checks the length of every serial tick against a ratio it computes itself from the count and the half-pixel, and finally checks that the whole line adds up to 3420 clocks.

// File: rtl/pce_pkg.sv
package pce_pkg;
  typedef enum logic {
    RATE_FAST = 1'b0,
    RATE_SLOW = 1'b1
  } rate_e;

  localparam int HCOUNT_W    = 9;
  localparam int FAST_DIV    = 4;
  localparam int SLOW_DIV    = 5;
  localparam int SYNC_TICKS  = 64;
  localparam int SEG_LONG    = 15;
  localparam int SEG_SHORT   = 2;
  localparam int SEG_COUNT   = 3;
endpackage

// File: rtl/pce_rate_sel.sv
module pce_rate_sel
  import pce_pkg::*;
#(
  parameter int               H_W        = HCOUNT_W,
  parameter int               TICKS      = SYNC_TICKS,
  parameter int               LONG_RUN   = SEG_LONG,
  parameter int               SHORT_RUN  = SEG_SHORT,
  parameter int               RUNS       = SEG_COUNT,
  parameter logic [H_W-1:0]   SYNC_START = 9'h1CD,
  parameter logic [H_W-1:0]   PORCH_SLOW = 9'h1ED
) (
  input  logic           wide,
  input  logic [H_W-1:0] hcount,
  input  logic           half,
  output rate_e          rate
);
  localparam int IDX_W     = $clog2(TICKS);
  localparam int PERIOD    = LONG_RUN + SHORT_RUN;
  localparam int SHORT_END = PERIOD * RUNS;

  logic [H_W-1:0]   off;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] pos;
  logic             in_sync;
  logic             short_slot;

  always_comb begin
    off        = hcount - SYNC_START;
    in_sync    = off < H_W'(TICKS / 2);
    idx        = {off[IDX_W-2:0], half};
    pos        = IDX_W'(int'(idx) % PERIOD);
    short_slot = in_sync && (int'(idx) < SHORT_END) && (int'(pos) >= LONG_RUN);
    if (!wide)                    rate = RATE_SLOW;
    else if (in_sync)             rate = short_slot ? RATE_FAST : RATE_SLOW;
    else if (hcount == PORCH_SLOW) rate = RATE_SLOW;
    else                          rate = RATE_FAST;
  end
endmodule

// File: rtl/pce_tick_gen.sv
module pce_tick_gen
  import pce_pkg::*;
#(
  parameter int FAST = FAST_DIV,
  parameter int SLOW = SLOW_DIV
) (
  input  logic  clk,
  input  logic  rst_n,
  input  rate_e rate,
  output logic  sclk_en,
  output logic  pix_en,
  output logic  half
);
  localparam int CNT_W = $clog2(SLOW);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim     = (rate == RATE_SLOW) ? CNT_W'(SLOW - 1) : CNT_W'(FAST - 1);
    sclk_en = (cnt >= lim);
    pix_en  = sclk_en & half;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      half <= 1'b0;
    end else if (sclk_en) begin
      cnt  <= '0;
      half <= ~half;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  // pixel enables alternate with plain serial ticks
  logic seen_tick;
  logic last_pix;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_tick <= 1'b0;
      last_pix  <= 1'b1;
    end else if (sclk_en) begin
      seen_tick <= 1'b1;
      last_pix  <= pix_en;
    end
  end

  p_pix_alternate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_en |-> (pix_en != last_pix));

  p_first_tick_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_en && !seen_tick) |-> !pix_en);
endmodule

// File: rtl/pixclk_enable_gen.sv
module pixclk_enable_gen
  import pce_pkg::*;
#(
  parameter int H_W = HCOUNT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wide_mode,
  input  logic [H_W-1:0] hcount,
  output logic           sclk_en,
  output logic           pix_en
);
  rate_e rate;
  logic  half;

  pce_rate_sel #(.H_W(H_W)) u_rate (
    .wide   (wide_mode),
    .hcount (hcount),
    .half   (half),
    .rate   (rate)
  );

  pce_tick_gen u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .rate    (rate),
    .sclk_en (sclk_en),
    .pix_en  (pix_en),
    .half    (half)
  );

  // interval watch: cycles since the previous serial tick
  logic [2:0] gap;
  logic       seen;
  logic       mode_moved;
  logic       wide_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap        <= '0;
      seen       <= 1'b0;
      mode_moved <= 1'b0;
      wide_q     <= wide_mode;
    end else begin
      wide_q <= wide_mode;
      if (sclk_en) begin
        gap        <= '0;
        seen       <= 1'b1;
        mode_moved <= 1'b0;
      end else begin
        if (gap != 3'd7) gap <= gap + 1'b1;
        if (wide_mode != wide_q) mode_moved <= 1'b1;
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!sclk_en && !pix_en));

  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_en && seen && !mode_moved) |-> (gap == 3'd3 || gap == 3'd4));

  p_narrow_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_en && seen && !mode_moved && !wide_mode && !wide_q) |-> (gap == 3'd4));
endmodule

// File: tb/sim_pixclk_enable_gen.sv
`timescale 1ns/1ps
module sim_pixclk_enable_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wide_mode = 1'b0;
  logic [8:0] hcount = 9'h000;
  logic       sclk_en, pix_en;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  always #2.5 clk = ~clk;

  pixclk_enable_gen u0 (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .hcount(hcount), .sclk_en(sclk_en), .pix_en(pix_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_div(input bit w, input logic [8:0] h, input bit hf);
    int i;
    if (!w) return 5;
    if (h >= 9'h1CD && h <= 9'h1EC) begin
      i = 2 * (int'(h) - 'h1CD) + int'(hf);
      if ((i >= 15 && i <= 16) || (i >= 32 && i <= 33) || (i >= 49 && i <= 50)) return 4;
      return 5;
    end
    if (h == 9'h1ED) return 5;
    return 4;
  endfunction

  function automatic logic [8:0] next_h(input bit w, input logic [8:0] h);
    if (!w && h == 9'h127) return 9'h1D2;
    if (w && h == 9'h16C) return 9'h1C9;
    return h + 9'd1;
  endfunction

  // reset with a fixed mode and count; leaves the bench at a negedge just after release
  task automatic do_reset(input bit w, input logic [8:0] h);
    @(negedge clk);
    rst_n = 1'b0; wide_mode = w; hcount = h;
    repeat (3) begin
      @(negedge clk);
      chk(!sclk_en && !pix_en, "R1 enables during reset", int'(sclk_en), 0);
    end
    rst_n = 1'b1;
  endtask

  // walks one full line, checking each tick length, pixel pairing and total length
  task automatic run_line(input bit w);
    int m = 0, since = 0, sync_sum = 0, porch_sum = 0;
    bit hf = 1'b0, se, pe, last = 1'b0;
    do_reset(w, 9'h000);
    while (!last && m < 5000) begin
      se = sclk_en; pe = pix_en;
      m++; since++;
      chk(pe == (se && hf), "R3 pixel on second serial tick", int'(pe), int'(se && hf));
      if (se) begin
        if (!w)
          chk(since == 5, "R2 narrow tick length", since, 5);
        else if (hcount >= 9'h1CD && hcount <= 9'h1EC)
          chk(since == exp_div(w, hcount, hf), "R5 sync window tick", since, exp_div(w, hcount, hf));
        else if (hcount == 9'h1ED)
          chk(since == 5, "R6 porch slow tick", since, 5);
        else
          chk(since == 4, "R4 wide plain tick", since, 4);
        if (w && hcount >= 9'h1CD && hcount <= 9'h1EC) sync_sum += since;
        if (w && hcount == 9'h1ED) porch_sum += since;
        since = 0;
        hf = ~hf;
      end
      if (pe && hcount == 9'h1FF) last = 1'b1;
      @(posedge clk);
      #1;
      if (pe) hcount = next_h(w, hcount);
      if (!last) @(negedge clk);
    end
    chk(m == 3420, w ? "R7 wide line length" : "R7 narrow line length", m, 3420);
    if (w) begin
      chk(sync_sum == 314, "R5 sync window total", sync_sum, 314);
      chk(porch_sum == 10, "R6 porch pixel total", porch_sum, 10);
    end
  endtask

  // holds the count still and checks a steady ratio
  task automatic hold_pos(input bit w, input logic [8:0] h, input int exp, input string req);
    int since = 0, ticks = 0, first = 1;
    do_reset(w, h);
    repeat (200) begin
      since++;
      if (sclk_en) begin
        ticks++;
        if (!first) chk(since == exp, req, since, exp);
        first = 0;
        since = 0;
      end
      @(negedge clk);
    end
    chk(ticks >= 40, req, ticks, 40);
  endtask

  task automatic t_first_cycle;
    do_reset(1'b1, 9'h000);
    chk(!sclk_en && !pix_en, "R1 first cycle after release", int'(sclk_en), 0);
    @(negedge clk);
    chk(!sclk_en, "R1 second cycle quiet", int'(sclk_en), 0);
  endtask

  task automatic t_narrow_line;  run_line(1'b0); endtask
  task automatic t_wide_line;    run_line(1'b1); endtask
  task automatic t_narrow_holds;
    hold_pos(1'b0, 9'h1D5, 5, "R2 narrow ignores sync count");
    hold_pos(1'b0, 9'h1ED, 5, "R2 narrow ignores porch count");
  endtask
  task automatic t_wide_holds;
    hold_pos(1'b1, 9'h050, 4, "R4 wide active region");
    hold_pos(1'b1, 9'h1ED, 5, "R6 wide held porch position");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_first_cycle();
    t_narrow_line();
    t_wide_line();
    t_narrow_holds();
    t_wide_holds();
    t_wide_line();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule